// File: doc/BRIEF.md
# Command/Response Mailbox Bus Bridge

This block lets a host reach a remote register space through only two ports: a 32-bit transfer port that carries both commands and responses, and a status port whose lowest bit flags that a response is waiting. The host writes a command word whose top byte selects the operation and whose low 24 bits give the register address. A write operation needs a second word on the transfer port holding the value to store. The bridge then runs one request/acknowledge handshake on its internal register bus.

Once the acknowledge arrives, the bridge queues its reply and raises the ready flag. A write, or an unknown operation, produces one status word. A read produces a status word followed by the read value. Each read strobe on the transfer port removes the word at the head of the queue. Ready falls when the queue is empty. While a command is in flight or a reply is still queued, new words written to the transfer port are dropped. A host can therefore always drain leftover replies by reading until ready clears, and then issue a fresh command.

Top module: `mbx_bridge`

## Requirements
- R1: A command word is split into an opcode in bits 31:24 and a register address in bits 23:0. During the internal access, `rb_addr` carries those 24 address bits.
- R2: Opcode 0x01 starts a single internal read: `rb_req` is high with `rb_we` low. The request, address and direction hold steady until `rb_ack` is sampled high.
- R3: Opcode 0x10 issues no internal request until a second transfer-port write arrives. The access then runs with `rb_we` high and `rb_wdata` equal to that second word.
- R4: `status_rdata[0]` (ready) goes high only on the clock edge that samples `rb_ack` high, or on the edge that accepts an unknown opcode. Bits 31:1 of the status port always read 0.
- R5: After a read completes, two words come out of the transfer port in this order: status 0x00000000, then the `rb_rdata` value captured with the acknowledge.
- R6: After a write completes, exactly one word comes out: status 0x00000000.
- R7: Ready stays high until the last queued word has been popped with `xfer_rd`, and drops on the edge that pops that word.
- R8: Any opcode other than 0x01 or 0x10 makes no internal request and queues one status word of value 0x00000001.
- R9: Transfer-port writes are ignored while an access is in flight or while ready is high. They change neither the queued replies nor the next internal access.
- R10: While ready is low, `xfer_rdata` reads 0 and `xfer_rd` has no effect. Reading until ready clears leaves the bridge able to take a new command.
- R11: A synchronous low `rst_n` clears ready, drops `rb_req` and discards all queued replies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_wr | input | 1 | Transfer-port write strobe, one cycle per word |
| xfer_wdata | input | 32 | Command or data word written by the host |
| xfer_rd | input | 1 | Transfer-port read strobe; pops the head reply word |
| xfer_rdata | output | 32 | Head reply word, 0 when nothing is queued |
| status_rdata | output | 32 | Status port; bit 0 is the ready flag |
| rb_req | output | 1 | Internal bus request, held until acknowledge |
| rb_addr | output | 24 | Internal bus register address |
| rb_we | output | 1 | Internal bus write enable |
| rb_wdata | output | 32 | Internal bus write data |
| rb_ack | input | 1 | Internal bus acknowledge, one cycle |
| rb_rdata | input | 32 | Internal bus read data, valid with acknowledge |

## Verification
The assertions assume that the register bus returns `rb_ack` only while `rb_req` is high, as a single-cycle pulse, and that the host strobes `xfer_wr` and `xfer_rd` for one cycle per word. The bench's bus model raises the acknowledge after a programmed wait only while the request is up, and drops it on the following cycle. All host strobes come from tasks that pulse for exactly one clock. Stray writes during busy periods are deliberate and lie inside this envelope, because the bridge must tolerate them.

// File: rtl/mbx_pkg.sv
// Package: shared opcodes, status codes and sequencer state for the mailbox bridge.
// Assumes a 32-bit transfer word with an 8-bit opcode above a 24-bit address.
package mbx_pkg;
    localparam logic [7:0]  OPC_READ   = 8'h01;
    localparam logic [7:0]  OPC_WRITE  = 8'h10;
    localparam logic [31:0] STS_OK     = 32'h0000_0000;
    localparam logic [31:0] STS_BAD_OP = 32'h0000_0001;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_WDATA  = 2'd1,
        SQ_ACCESS = 2'd2
    } seq_state_e;
endpackage

// File: rtl/mbx_cmd_decode.sv
// Module: splits a transfer-port word into opcode flags and register address.
// Assumes OP_W + ADDR_W == DATA_W with the opcode in the upper bits.
module mbx_cmd_decode #(
    parameter int DATA_W = 32,
    parameter int OP_W   = 8,
    parameter int ADDR_W = DATA_W - OP_W
) (
    input  logic [DATA_W-1:0] word,
    output logic              is_rd,
    output logic              is_wr,
    output logic [ADDR_W-1:0] addr
);
    import mbx_pkg::*;

    logic [OP_W-1:0] opcode;

    // Field split and opcode compare.
    always_comb begin
        opcode = word[DATA_W-1 -: OP_W];
        addr   = word[ADDR_W-1:0];
        is_rd  = (opcode == OP_W'(OPC_READ));
        is_wr  = (opcode == OP_W'(OPC_WRITE));
    end
endmodule

// File: rtl/mbx_resp_queue.sv
// Module: holds up to DEPTH reply words, loaded all at once, popped in order.
// Assumes load is only requested while the queue is empty.
module mbx_resp_queue #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [CNT_W-1:0]             load_cnt,
    input  logic [DEPTH-1:0][DATA_W-1:0] load_words,
    input  logic                         pop,
    output logic [DATA_W-1:0]            head,
    output logic                         avail
);
    logic [DEPTH-1:0][DATA_W-1:0] slots;
    logic [CNT_W-1:0]             remain;
    logic [IDX_W-1:0]             rd_idx;

    // Reply storage, replaced on load.
    always_ff @(posedge clk) begin
        if (!rst_n)    slots <= '0;
        else if (load) slots <= load_words;
    end

    // Remaining-word count and read index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            rd_idx <= '0;
        end else if (load) begin
            remain <= load_cnt;
            rd_idx <= '0;
        end else if (pop && avail) begin
            remain <= remain - CNT_W'(1);
            rd_idx <= rd_idx + IDX_W'(1);
        end
    end

    // Head word, forced to zero when nothing is queued.
    always_comb begin
        avail = (remain != '0);
        head  = avail ? slots[rd_idx] : '0;
    end
endmodule

// File: rtl/mbx_seq.sv
// Module: command sequencer; collects command and data words, runs one bus
// handshake, and builds the reply words for the queue.
// Assumes bus_ack arrives only while bus_req is high.
module mbx_seq #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24,
    parameter int DEPTH  = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_wr,
    input  logic [DATA_W-1:0]            cmd_word,
    input  logic                         dec_rd,
    input  logic                         dec_wr,
    input  logic [ADDR_W-1:0]            dec_addr,
    input  logic                         reply_pending,
    input  logic                         bus_ack,
    input  logic [DATA_W-1:0]            bus_rdata,
    output logic                         bus_req,
    output logic [ADDR_W-1:0]            bus_addr,
    output logic                         bus_we,
    output logic [DATA_W-1:0]            bus_wdata,
    output logic                         q_load,
    output logic [CNT_W-1:0]             q_cnt,
    output logic [DEPTH-1:0][DATA_W-1:0] q_words
);
    import mbx_pkg::*;

    seq_state_e state;
    logic       accept;

    // A command is taken only in idle with no reply outstanding.
    assign accept  = cmd_wr && !reply_pending && (state == SQ_IDLE);
    assign bus_req = (state == SQ_ACCESS);

    // State, address, direction and write-data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            bus_addr  <= '0;
            bus_we    <= 1'b0;
            bus_wdata <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (accept && (dec_rd || dec_wr)) begin
                    bus_addr <= dec_addr;
                    bus_we   <= dec_wr;
                    state    <= dec_rd ? SQ_ACCESS : SQ_WDATA;
                end
                SQ_WDATA: if (cmd_wr) begin
                    bus_wdata <= cmd_word;
                    state     <= SQ_ACCESS;
                end
                SQ_ACCESS: if (bus_ack) state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Reply words: status then data on read, status only otherwise.
    always_comb begin
        q_load  = 1'b0;
        q_cnt   = '0;
        q_words = '0;
        if (bus_req && bus_ack) begin
            q_load     = 1'b1;
            q_words[0] = STS_OK;
            if (!bus_we) begin
                q_words[1] = bus_rdata;
                q_cnt      = CNT_W'(2);
            end else begin
                q_cnt      = CNT_W'(1);
            end
        end else if (accept && !dec_rd && !dec_wr) begin
            q_load     = 1'b1;
            q_words[0] = STS_BAD_OP;
            q_cnt      = CNT_W'(1);
        end
    end
endmodule

// File: rtl/mbx_bridge.sv
// Module: top of the mailbox bridge; wires decoder, sequencer and reply queue.
// Assumes single-cycle host strobes and a one-ack-per-request register bus.
module mbx_bridge #(
    parameter int DATA_W     = 32,
    parameter int OP_W       = 8,
    parameter int RESP_DEPTH = 2,
    localparam int ADDR_W    = DATA_W - OP_W,
    localparam int CNT_W     = $clog2(RESP_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_wr,
    input  logic [DATA_W-1:0] xfer_wdata,
    input  logic              xfer_rd,
    output logic [DATA_W-1:0] xfer_rdata,
    output logic [DATA_W-1:0] status_rdata,
    output logic              rb_req,
    output logic [ADDR_W-1:0] rb_addr,
    output logic              rb_we,
    output logic [DATA_W-1:0] rb_wdata,
    input  logic              rb_ack,
    input  logic [DATA_W-1:0] rb_rdata
);
    logic                             dec_rd, dec_wr;
    logic [ADDR_W-1:0]                dec_addr;
    logic                             q_load, q_avail;
    logic [CNT_W-1:0]                 q_cnt;
    logic [RESP_DEPTH-1:0][DATA_W-1:0] q_words;

    mbx_cmd_decode #(.DATA_W(DATA_W), .OP_W(OP_W), .ADDR_W(ADDR_W)) i_dec (
        .word  (xfer_wdata),
        .is_rd (dec_rd),
        .is_wr (dec_wr),
        .addr  (dec_addr)
    );

    mbx_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(RESP_DEPTH)) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_wr        (xfer_wr),
        .cmd_word      (xfer_wdata),
        .dec_rd        (dec_rd),
        .dec_wr        (dec_wr),
        .dec_addr      (dec_addr),
        .reply_pending (q_avail),
        .bus_ack       (rb_ack),
        .bus_rdata     (rb_rdata),
        .bus_req       (rb_req),
        .bus_addr      (rb_addr),
        .bus_we        (rb_we),
        .bus_wdata     (rb_wdata),
        .q_load        (q_load),
        .q_cnt         (q_cnt),
        .q_words       (q_words)
    );

    mbx_resp_queue #(.DATA_W(DATA_W), .DEPTH(RESP_DEPTH)) i_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (q_load),
        .load_cnt   (q_cnt),
        .load_words (q_words),
        .pop        (xfer_rd),
        .head       (xfer_rdata),
        .avail      (q_avail)
    );

    // Status port: ready flag in bit 0, upper bits zero.
    assign status_rdata = {{(DATA_W-1){1'b0}}, q_avail};
endmodule

// File: rtl/mbx_bridge_chk.sv
// Module: protocol checker for the mailbox bridge, bound to every instance.
// Assumes rb_ack is a one-cycle pulse given only while rb_req is high.
module mbx_bridge_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_wr,
    input logic              xfer_rd,
    input logic [DATA_W-1:0] xfer_rdata,
    input logic [DATA_W-1:0] status_rdata,
    input logic              rb_req,
    input logic [ADDR_W-1:0] rb_addr,
    input logic              rb_we,
    input logic              rb_ack
);
    logic ready;
    assign ready = status_rdata[0];

    // R2: request, address and direction hold until acknowledged.
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rb_req && !rb_ack |=> rb_req && $stable(rb_addr) && $stable(rb_we));

    // R4: ready rises only after an acknowledge or an accepted write.
    p_ready_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(rb_req && rb_ack) || $past(xfer_wr));

    // R7: ready never drops without a pop.
    p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !xfer_rd |=> ready);

    // R9: no bus access starts while a reply is queued.
    p_no_req_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !rb_req);

    // R10: empty queue presents zero on the transfer port.
    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> xfer_rdata == '0);

    // R4: upper status bits are always zero.
    p_status_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status_rdata[DATA_W-1:1] == '0);
endmodule

bind mbx_bridge mbx_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_mbx_bridge.sv
module test_mbx_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_wr = 1'b0;
    logic [31:0] xfer_wdata = '0;
    logic        xfer_rd = 1'b0;
    logic [31:0] xfer_rdata, status_rdata;
    logic        rb_req, rb_we;
    logic [23:0] rb_addr;
    logic [31:0] rb_wdata;
    logic        rb_ack = 1'b0;
    logic [31:0] rb_rdata = '0;

    int checks = 0, fails = 0;
    int acks = 0, wait_cnt = 0, lat = 0;
    logic [23:0] seen_addr = '0;
    logic        seen_we = 1'b0;
    logic [31:0] seen_wd = '0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    mbx_bridge i_mbx_bridge (.*);

    function automatic logic [31:0] model_rd(input logic [23:0] a);
        return {8'hA5, a} ^ {a, 8'h3C};
    endfunction

    // Register-bus model: ack after lat waiting cycles, one-cycle pulse.
    initial forever begin
        @(negedge clk);
        if (rb_ack) rb_ack = 1'b0;
        else if (rb_req) begin
            if (wait_cnt >= lat) begin
                rb_ack = 1'b1; rb_rdata = model_rd(rb_addr);
                seen_addr = rb_addr; seen_we = rb_we; seen_wd = rb_wdata;
                acks++; wait_cnt = 0;
            end else wait_cnt++;
        end else wait_cnt = 0;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] w);
        @(negedge clk); xfer_wr = 1'b1; xfer_wdata = w;
        @(negedge clk); xfer_wr = 1'b0;
    endtask

    task automatic host_read(output logic [31:0] w);
        @(negedge clk); w = xfer_rdata; xfer_rd = 1'b1;
        @(negedge clk); xfer_rd = 1'b0;
    endtask

    task automatic wait_ready();
        for (int n = 0; n < 50 && !status_rdata[0]; n++) @(negedge clk);
    endtask

    // Vector: opcode, address, write data, bus latency.
    localparam logic [71:0] VEC [6] = '{
        {8'h01, 24'h000010, 32'h0000_0000, 8'd0},
        {8'h10, 24'h000020, 32'hDEAD_BEEF, 8'd2},
        {8'h01, 24'hFFFFFF, 32'h0000_0000, 8'd4},
        {8'h10, 24'h000000, 32'h0000_0001, 8'd0},
        {8'h7F, 24'h123456, 32'h0000_0000, 8'd0},
        {8'h00, 24'h000001, 32'h0000_0000, 8'd0}
    };

    initial begin
        logic [31:0] w;
        int a0, pops;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(status_rdata == 0, "R11 ready after reset", status_rdata, 0);
        chk(rb_req == 0, "R11 req after reset", {31'b0, rb_req}, 0);
        chk(xfer_rdata == 0, "R11 rdata after reset", xfer_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VEC[i]) begin
            logic [7:0] op = VEC[i][71:64];
            logic [23:0] ad = VEC[i][63:40];
            logic [31:0] dt = VEC[i][39:8];
            lat = int'(VEC[i][7:0]);
            a0 = acks;
            host_write({op, ad});
            if (op == 8'h01) begin
                wait_ready();
                chk(acks == a0 + 1 && seen_we == 0, "R2 one read access", acks, a0 + 1);
                chk(seen_addr == ad, "R1 address field", {8'h0, seen_addr}, {8'h0, ad});
                host_read(w);
                chk(w == 0, "R5 read status word", w, 0);
                chk(status_rdata[0] == 1, "R7 ready held mid-reply", status_rdata, 1);
                host_read(w);
                chk(w == model_rd(ad), "R5 read data word", w, model_rd(ad));
                chk(status_rdata == 0, "R7 ready drops on last pop", status_rdata, 0);
            end else if (op == 8'h10) begin
                repeat (3) @(negedge clk);
                chk(acks == a0 && !rb_req, "R3 no access before data", acks, a0);
                host_write(dt);
                wait_ready();
                chk(seen_we == 1 && seen_wd == dt && seen_addr == ad, "R3 write access", seen_wd, dt);
                host_read(w);
                chk(w == 0, "R6 write status word", w, 0);
                chk(status_rdata == 0, "R6 single reply word", status_rdata, 0);
            end else begin
                wait_ready();
                chk(acks == a0, "R8 no access on bad opcode", acks, a0);
                host_read(w);
                chk(w == 32'h1, "R8 bad opcode status", w, 1);
                chk(status_rdata == 0, "R8 single reply word", status_rdata, 0);
            end
        end

        // R4: ready stays low until the ack cycle
        lat = 3; a0 = acks;
        host_write(32'h0100_0042);
        chk(rb_req == 1 && status_rdata == 0, "R4 busy, not ready", status_rdata, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(status_rdata == 0, "R4 not ready before ack", status_rdata, 0);
        end
        @(negedge clk);
        chk(status_rdata == 1, "R4 ready after ack", status_rdata, 1);
        host_read(w); host_read(w);

        // R9: writes while busy and while pending are dropped
        lat = 3; a0 = acks;
        host_write(32'h0100_0077);
        host_write(32'h1000_0099);
        wait_ready();
        host_write(32'h0100_0055);
        host_write(32'h7F00_0000);
        repeat (2) @(negedge clk);
        chk(acks == a0 + 1 && seen_addr == 24'h77, "R9 only one access", acks, a0 + 1);
        host_read(w);
        chk(w == 0, "R9 status unchanged", w, 0);
        host_read(w);
        chk(w == model_rd(24'h77), "R9 data unchanged", w, model_rd(24'h77));
        chk(status_rdata == 0 && !rb_req, "R9 idle after replies", status_rdata, 0);

        // R10: reads while empty are harmless; drain leftovers
        chk(xfer_rdata == 0, "R10 empty rdata", xfer_rdata, 0);
        host_read(w);
        chk(status_rdata == 0 && w == 0, "R10 pop while empty", status_rdata, 0);
        lat = 0;
        host_write(32'h0100_0300);
        wait_ready();
        pops = 0;
        while (status_rdata[0] && pops < 8) begin host_read(w); pops++; end
        chk(pops == 2, "R10 drain read leftovers", pops, 2);
        host_write(32'h1000_0301); host_write(32'h0000_ABCD);
        wait_ready();
        chk(seen_wd == 32'hABCD && seen_addr == 24'h301, "R10 command after drain", seen_wd, 32'hABCD);
        pops = 0;
        while (status_rdata[0] && pops < 8) begin host_read(w); pops++; end
        chk(pops == 1, "R10 drain write leftovers", pops, 1);

        // R11: reset with a reply queued
        host_write(32'h0100_0400);
        wait_ready();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status_rdata == 0 && xfer_rdata == 0 && !rb_req, "R11 reset clears queue", status_rdata, 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule